// File: doc/BRIEF.md
# MDIO PHY management slave

This block is the PHY end of a clause-22 serial management link. The station manager toggles a management clock (MDC) and a bidirectional data line (MDIO) by software or by a simple shifter. The block oversamples both lines with the system clock and decodes each management frame. A frame is a run of preamble ones, a start pattern, an opcode, a PHY address, a register address, a turnaround and sixteen data bits. The block then either captures a register write or drives read data back through a tri-state control pair.

The register file holds thirty-two 16-bit words. Most of them read back what was last written. Three reads are computed instead:

- The status word reports fixed abilities and the live link input.
- The partner-ability word mirrors the local advertisement, so negotiation always appears to land on the best mode offered.
- A diagnostics word reports the resolved speed and duplex from that same advertisement.

Frames that carry another PHY address, or an opcode that is neither read nor write, leave the bus undriven and the registers unchanged.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is accepted only after at least 32 consecutive one bits sampled on MDC rising edges, followed by the start pattern 0 then 1. A run of 31 ones followed by a frame produces no response.
- R2: After the start pattern come a 2-bit opcode, a 5-bit PHY address, a 5-bit register address, two turnaround bit times and 16 data bits, each field sent MSB first. After the last data bit the block hunts for a fresh preamble, so frames can follow one another.
- R3: A write (opcode 01) to the block's own address stores the 16 data bits in the addressed register. A later read of a plain register returns that value. The block never drives MDIO during a write frame.
- R4: In a read (opcode 10), mdio_oe stays low during the first turnaround bit time and the block drives 0 during the second. It then drives the 16 data bits MSB first, each launched after an MDC falling edge. mdio_oe returns low after the frame, and mdio_oe only changes after an MDC falling edge.
- R5: After reset, mdio_oe is low and the registers hold: index 0 = 0x3100, index 2 = 0x0300, index 3 = 0xE400, index 4 (advertisement) = 0x01E1, all others 0.
- R6: A read of index 1 returns 0x7828 with bit 2 equal to link_up, giving 0x782C when the link is up.
- R7: A read of index 5 returns 0x4000 OR (index-4 contents AND 0x01E0).
- R8: A read of index 18 returns 0 except two bits. Bit 10 is set when index 4 has bit 7 or bit 8 set. Bit 11 is set when index 4 has bit 8 or bit 6 set.
- R9: A frame whose PHY address differs from parameter PHY_ADDR (default 1) never drives MDIO and stores nothing.
- R10: An opcode of 00 or 11 aborts the frame: MDIO is not driven, nothing is stored, and a new preamble is required.
- R11: Writes to indices 1, 5 and 18 do not change what those indices read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples MDC and MDIO |
| rst_n | input | 1 | Active-low synchronous reset |
| mdc | input | 1 | Management clock from the station manager |
| mdio_i | input | 1 | MDIO pad input |
| link_up | input | 1 | Live link indication reported in the status word |
| mdio_o | output | 1 | MDIO pad output value |
| mdio_oe | output | 1 | MDIO pad output enable (1 = drive) |

## Verification
A wrong frame state shows up at the pins within one frame. A miscounted field makes the turnaround drive start a bit early or late. Read data then comes back shifted by one or more positions, or mdio_oe rises on a frame that should be ignored. A wrong stored word or a wrong derived-register formula shows up on the very next read of that index, and again whenever the advertisement word is rewritten. A preamble counter that accepts too few ones is caught by a frame with a 31-bit preamble that gets an answer.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 5;
    localparam int NUM_REGS = 1 << ADDR_W;
    localparam int PRE_MIN  = 32;
    localparam int CNT_W    = $clog2(PRE_MIN + 1);

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_OPC,
        ST_PHYAD,
        ST_REGAD,
        ST_TURN,
        ST_DATA
    } frame_st_e;

    localparam logic [1:0] OPC_RD = 2'b10;
    localparam logic [1:0] OPC_WR = 2'b01;

    localparam logic [ADDR_W-1:0] IDX_CTRL = 5'd0;
    localparam logic [ADDR_W-1:0] IDX_STAT = 5'd1;
    localparam logic [ADDR_W-1:0] IDX_ID1  = 5'd2;
    localparam logic [ADDR_W-1:0] IDX_ID2  = 5'd3;
    localparam logic [ADDR_W-1:0] IDX_ADV  = 5'd4;
    localparam logic [ADDR_W-1:0] IDX_LPA  = 5'd5;
    localparam logic [ADDR_W-1:0] IDX_DIAG = 5'd18;

    localparam logic [DATA_W-1:0] RST_CTRL   = 16'h3100;
    localparam logic [DATA_W-1:0] RST_ID1    = 16'h0300;
    localparam logic [DATA_W-1:0] RST_ID2    = 16'hE400;
    localparam logic [DATA_W-1:0] RST_ADV    = 16'h01E1;
    localparam logic [DATA_W-1:0] STAT_FIXED = 16'h7828;
    localparam logic [DATA_W-1:0] LPA_ACK    = 16'h4000;
    localparam logic [DATA_W-1:0] ADV_MODES  = 16'h01E0;

    typedef logic [NUM_REGS-1:0][DATA_W-1:0] reg_array_t;

    function automatic reg_array_t regs_reset();
        reg_array_t r;
        r = '0;
        r[IDX_CTRL] = RST_CTRL;
        r[IDX_ID1]  = RST_ID1;
        r[IDX_ID2]  = RST_ID2;
        r[IDX_ADV]  = RST_ADV;
        return r;
    endfunction
endpackage

// File: rtl/mdio_edge_sync.sv
`timescale 1ns/1ps
module mdio_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc,
    input  logic mdio_i,
    output logic mdc_rise,
    output logic mdc_fall,
    output logic bit_o
);
    typedef struct packed {
        logic [STAGES-1:0] mdc_sh;
        logic [STAGES-1:0] dat_sh;
        logic              mdc_prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d          = sync_q;
        sync_d.mdc_sh   = {sync_q.mdc_sh[STAGES-2:0], mdc};
        sync_d.dat_sh   = {sync_q.dat_sh[STAGES-2:0], mdio_i};
        sync_d.mdc_prev = sync_q.mdc_sh[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign mdc_rise = sync_q.mdc_sh[STAGES-1] & ~sync_q.mdc_prev;
    assign mdc_fall = ~sync_q.mdc_sh[STAGES-1] & sync_q.mdc_prev;
    assign bit_o    = sync_q.dat_sh[STAGES-1];
endmodule

// File: rtl/mdio_frame_fsm.sv
`timescale 1ns/1ps
module mdio_frame_fsm
    import mdio_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PHY_ADDR = 5'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdc_rise,
    input  logic              mdc_fall,
    input  logic              bit_i,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              mdio_o,
    output logic              mdio_oe
);
    typedef struct packed {
        frame_st_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [1:0]        opc;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] reg_a;
        logic [DATA_W-1:0] sh;
        logic              is_rd;
        logic              hit;
        logic              wr;
        logic              oe;
        logic              dout;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic [1:0] opc_full;

    // register index completed by the current bit, used to snapshot read data
    assign rd_addr  = {fsm_q.reg_a[ADDR_W-2:0], bit_i};
    assign opc_full = {fsm_q.opc[0], bit_i};

    always_comb begin
        fsm_d    = fsm_q;
        fsm_d.wr = 1'b0;
        if (mdc_rise) begin
            case (fsm_q.state)
                ST_HUNT: begin
                    if (bit_i) begin
                        if (fsm_q.cnt != CNT_W'(PRE_MIN)) fsm_d.cnt = fsm_q.cnt + 1'b1;
                    end else begin
                        fsm_d.cnt = '0;
                        if (fsm_q.cnt == CNT_W'(PRE_MIN)) fsm_d.state = ST_START;
                    end
                end
                ST_START: begin
                    fsm_d.cnt   = '0;
                    fsm_d.state = bit_i ? ST_OPC : ST_HUNT;
                end
                ST_OPC: begin
                    fsm_d.opc = opc_full;
                    if (fsm_q.cnt == CNT_W'(1)) begin
                        fsm_d.cnt = '0;
                        if (opc_full == OPC_RD || opc_full == OPC_WR) begin
                            fsm_d.state = ST_PHYAD;
                            fsm_d.is_rd = (opc_full == OPC_RD);
                        end else begin
                            fsm_d.state = ST_HUNT;
                        end
                    end else begin
                        fsm_d.cnt = fsm_q.cnt + 1'b1;
                    end
                end
                ST_PHYAD: begin
                    fsm_d.phy = {fsm_q.phy[ADDR_W-2:0], bit_i};
                    if (fsm_q.cnt == CNT_W'(ADDR_W - 1)) begin
                        fsm_d.cnt   = '0;
                        fsm_d.state = ST_REGAD;
                    end else begin
                        fsm_d.cnt = fsm_q.cnt + 1'b1;
                    end
                end
                ST_REGAD: begin
                    fsm_d.reg_a = rd_addr;
                    if (fsm_q.cnt == CNT_W'(ADDR_W - 1)) begin
                        fsm_d.cnt   = '0;
                        fsm_d.state = ST_TURN;
                        fsm_d.hit   = (fsm_q.phy == PHY_ADDR);
                        fsm_d.sh    = rd_data;
                    end else begin
                        fsm_d.cnt = fsm_q.cnt + 1'b1;
                    end
                end
                ST_TURN: begin
                    if (fsm_q.cnt == CNT_W'(1)) begin
                        fsm_d.cnt   = '0;
                        fsm_d.state = ST_DATA;
                    end else begin
                        fsm_d.cnt = fsm_q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    fsm_d.sh = {fsm_q.sh[DATA_W-2:0], bit_i};
                    if (fsm_q.cnt == CNT_W'(DATA_W - 1)) begin
                        fsm_d.cnt   = '0;
                        fsm_d.state = ST_HUNT;
                        fsm_d.wr    = fsm_q.hit & ~fsm_q.is_rd;
                    end else begin
                        fsm_d.cnt = fsm_q.cnt + 1'b1;
                    end
                end
                default: begin
                    fsm_d.cnt   = '0;
                    fsm_d.state = ST_HUNT;
                end
            endcase
        end
        if (mdc_fall) begin
            fsm_d.oe   = 1'b0;
            fsm_d.dout = 1'b0;
            if (fsm_q.hit && fsm_q.is_rd) begin
                if (fsm_q.state == ST_TURN && fsm_q.cnt == CNT_W'(1)) begin
                    fsm_d.oe = 1'b1;
                end else if (fsm_q.state == ST_DATA) begin
                    fsm_d.oe   = 1'b1;
                    fsm_d.dout = fsm_q.sh[DATA_W-1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fsm_q <= '{state: ST_HUNT, default: '0};
        else        fsm_q <= fsm_d;
    end

    assign wr_en   = fsm_q.wr;
    assign wr_addr = fsm_q.reg_a;
    assign wr_data = fsm_q.sh;
    assign mdio_o  = fsm_q.dout;
    assign mdio_oe = fsm_q.oe;

    assert_pre_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_START && $past(fsm_q.state) != ST_START)
            |-> $past(fsm_q.cnt) == CNT_W'(PRE_MIN));

    assert_drive_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> (fsm_q.state == ST_TURN && fsm_q.cnt == CNT_W'(1)));

    assert_oe_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mdc_fall |=> $stable(mdio_oe));

    assert_write_own_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (fsm_q.phy == PHY_ADDR && !fsm_q.is_rd));

    assert_valid_opc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_PHYAD && $past(fsm_q.state) == ST_OPC)
            |-> (fsm_q.opc == OPC_RD || fsm_q.opc == OPC_WR));
endmodule

// File: rtl/mdio_phy_regs.sv
`timescale 1ns/1ps
module mdio_phy_regs
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              link_up,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        reg_array_t mem;
    } regs_t;

    localparam regs_t REGS_RST = '{mem: regs_reset()};

    regs_t regs_d, regs_q;
    logic [DATA_W-1:0] adv;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) regs_d.mem[wr_addr] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= REGS_RST;
        else        regs_q <= regs_d;
    end

    assign adv = regs_q.mem[IDX_ADV];

    always_comb begin
        case (rd_addr)
            IDX_STAT: rd_data = STAT_FIXED | {13'd0, link_up, 2'b00};
            IDX_LPA:  rd_data = LPA_ACK | (adv & ADV_MODES);
            IDX_DIAG: rd_data = {4'b0000, adv[8] | adv[6], adv[8] | adv[7], 10'd0};
            default:  rd_data = regs_q.mem[rd_addr];
        endcase
    end

    assert_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> regs_q.mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/mdio_mgmt_slave.sv
`timescale 1ns/1ps
module mdio_mgmt_slave
    import mdio_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PHY_ADDR    = 5'd1,
    parameter int                SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc,
    input  logic mdio_i,
    input  logic link_up,
    output logic mdio_o,
    output logic mdio_oe
);
    logic              mdc_rise, mdc_fall, bit_s;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;

    mdio_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mdc      (mdc),
        .mdio_i   (mdio_i),
        .mdc_rise (mdc_rise),
        .mdc_fall (mdc_fall),
        .bit_o    (bit_s)
    );

    mdio_frame_fsm #(.PHY_ADDR(PHY_ADDR)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mdc_rise (mdc_rise),
        .mdc_fall (mdc_fall),
        .bit_i    (bit_s),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    mdio_phy_regs regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .link_up (link_up),
        .rd_data (rd_data)
    );
endmodule

// File: tb/mdio_mgmt_slave_tb_top.sv
`timescale 1ns/1ps
module mdio_mgmt_slave_tb_top;
    localparam logic [4:0] MY_PHY = 5'd1;
    localparam int         HALF   = 8;
    localparam logic [1:0] RD     = 2'b10;
    localparam logic [1:0] WR     = 2'b01;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mdc = 1'b0;
    logic mdio_i = 1'b1;
    logic link_up = 1'b1;
    logic mdio_o, mdio_oe;
    int n_checks = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    mdio_mgmt_slave #(.PHY_ADDR(MY_PHY)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mdc     (mdc),
        .mdio_i  (mdio_i),
        .link_up (link_up),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    // fields: [37] write, [36:32] register, [31:16] write data, [15:0] expected read
    localparam int NV = 25;
    localparam logic [37:0] VEC [NV] = '{
        {1'b0, 5'd0,  16'h0000, 16'h3100},  // R5
        {1'b0, 5'd2,  16'h0000, 16'h0300},  // R5
        {1'b0, 5'd3,  16'h0000, 16'hE400},  // R5
        {1'b0, 5'd4,  16'h0000, 16'h01E1},  // R5
        {1'b0, 5'd1,  16'h0000, 16'h782C},  // R6 link up
        {1'b0, 5'd5,  16'h0000, 16'h41E0},  // R7
        {1'b0, 5'd18, 16'h0000, 16'h0C00},  // R8 both bits
        {1'b1, 5'd4,  16'h0021, 16'h0000},
        {1'b0, 5'd4,  16'h0000, 16'h0021},  // R3
        {1'b0, 5'd5,  16'h0000, 16'h4020},  // R7
        {1'b0, 5'd18, 16'h0000, 16'h0000},  // R8 10 half only
        {1'b1, 5'd4,  16'h0041, 16'h0000},
        {1'b0, 5'd18, 16'h0000, 16'h0800},  // R8 10 full
        {1'b1, 5'd4,  16'h0081, 16'h0000},
        {1'b0, 5'd18, 16'h0000, 16'h0400},  // R8 100 half
        {1'b1, 5'd9,  16'hA5C3, 16'h0000},
        {1'b0, 5'd9,  16'h0000, 16'hA5C3},  // R3
        {1'b1, 5'd1,  16'hFFFF, 16'h0000},
        {1'b0, 5'd1,  16'h0000, 16'h782C},  // R11
        {1'b1, 5'd18, 16'h1234, 16'h0000},
        {1'b0, 5'd18, 16'h0000, 16'h0400},  // R11
        {1'b1, 5'd31, 16'h5A5A, 16'h0000},
        {1'b0, 5'd31, 16'h0000, 16'h5A5A},  // R3
        {1'b1, 5'd5,  16'h0000, 16'h0000},
        {1'b0, 5'd5,  16'h0000, 16'h4080}   // R11
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bit_time(input logic b, output logic so, output logic soe);
        @(negedge clk);
        mdc    = 1'b0;
        mdio_i = b;
        repeat (HALF) @(negedge clk);
        so  = mdio_o;
        soe = mdio_oe;
        mdc = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic frame(input int pre_n, input logic [1:0] op, input logic [4:0] phy,
                         input logic [4:0] rg, input logic [15:0] wd,
                         output logic [15:0] rv, output logic ta1_oe, output logic ta2_ok,
                         output int oe_cnt);
        logic so, soe;
        logic [13:0] hdr;
        hdr    = {2'b01, op, phy, rg};
        oe_cnt = 0;
        rv     = '0;
        for (int i = 0; i < pre_n; i++) begin
            bit_time(1'b1, so, soe);
            oe_cnt += int'(soe);
        end
        for (int i = 13; i >= 0; i--) begin
            bit_time(hdr[i], so, soe);
            oe_cnt += int'(soe);
        end
        bit_time(1'b1, so, soe);
        ta1_oe = soe;
        oe_cnt += int'(soe);
        bit_time(op == WR ? 1'b0 : 1'b1, so, soe);
        ta2_ok = soe && !so;
        oe_cnt += int'(soe);
        for (int i = 15; i >= 0; i--) begin
            bit_time(op == WR ? wd[i] : 1'b1, so, soe);
            rv[i] = so;
            oe_cnt += int'(soe);
        end
        // zero guard bit: breaks any run of ones before the next preamble
        bit_time(1'b0, so, soe);
        oe_cnt += int'(soe);
    endtask

    task automatic good_read(input logic [4:0] rg, input logic [15:0] exp, input string req);
        logic [15:0] rv;
        logic t1, t2;
        int oc;
        frame(32, RD, MY_PHY, rg, 16'h0, rv, t1, t2, oc);
        check(rv == exp, req, rv, exp);
        check(!t1 && t2 && oc == 17, "R4 turnaround and drive window", {t1, t2, oc[7:0]}, {2'b01, 8'd17});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] rv;
        logic t1, t2;
        int oc;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(mdio_oe == 1'b0, "R5 oe low after reset", mdio_oe, 0);

        // table of vectors, preamble lengths 32..34 (R1, R2)
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][37]) begin
                frame(32 + (v % 3), WR, MY_PHY, VEC[v][36:32], VEC[v][31:16], rv, t1, t2, oc);
                check(oc == 0, "R3 write frame leaves bus undriven", oc, 0);
            end else begin
                frame(32 + (v % 3), RD, MY_PHY, VEC[v][36:32], 16'h0, rv, t1, t2, oc);
                check(rv == VEC[v][15:0], "R2 read data MSB first", rv, VEC[v][15:0]);
                check(!t1 && t2 && oc == 17, "R4 turnaround and drive window",
                      {t1, t2, oc[7:0]}, {2'b01, 8'd17});
            end
        end

        // R6: link down clears bit 2
        link_up = 1'b0;
        good_read(5'd1, 16'h7828, "R6 status with link down");
        link_up = 1'b1;

        // R9: foreign PHY address
        frame(32, WR, MY_PHY + 5'd1, 5'd9, 16'h1111, rv, t1, t2, oc);
        check(oc == 0, "R9 foreign write not driven", oc, 0);
        frame(32, RD, MY_PHY + 5'd1, 5'd9, 16'h0, rv, t1, t2, oc);
        check(oc == 0, "R9 foreign read not driven", oc, 0);
        good_read(5'd9, 16'hA5C3, "R9 foreign write stored nothing");

        // R10: invalid opcodes
        frame(32, 2'b11, MY_PHY, 5'd9, 16'h0F0F, rv, t1, t2, oc);
        check(oc == 0, "R10 opcode 11 not driven", oc, 0);
        frame(32, 2'b00, MY_PHY, 5'd9, 16'h0F0F, rv, t1, t2, oc);
        check(oc == 0, "R10 opcode 00 not driven", oc, 0);
        good_read(5'd9, 16'hA5C3, "R10 aborted frames stored nothing");

        // R1: 31 ones are not a preamble
        frame(31, RD, MY_PHY, 5'd0, 16'h0, rv, t1, t2, oc);
        check(oc == 0, "R1 short preamble ignored", oc, 0);
        frame(31, WR, MY_PHY, 5'd9, 16'h7777, rv, t1, t2, oc);
        good_read(5'd9, 16'hA5C3, "R1 short preamble write ignored");

        // R5: reset restores the advertisement word
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(mdio_oe == 1'b0, "R5 oe low after second reset", mdio_oe, 0);
        good_read(5'd4, 16'h01E1, "R5 advertisement after reset");
        good_read(5'd9, 16'h0000, "R5 plain register cleared by reset");

        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule